// File: doc/BRIEF.md
# Serial Configuration Loader

This block brings up an FPGA whose configuration port takes one serial data bit per clock. After a start request it takes the shared parallel ROM bus. It drives the target's active-low program line low for a fixed hold time and then releases it. It then waits until the target lets its active-low init line go high. Shifting begins as soon as that line is seen high, with no fixed settling delay. The loader then reads the bitstream words from address zero upward and shifts each word out most significant bit first, one bit per generated configuration clock.

Once the last bit has been sent, the loader holds the data line at 1 and keeps the configuration clock running. When the target raises its done line, the loader gives a fixed number of further rising edges so the target can finish its startup. It then stops the clock and hands the ROM bus back to the configured device. A target that never releases init, or never raises done, trips a timeout. The loader then flags an error and starts the whole sequence again. Bitstream length, clock half-period, ROM read latency, program hold time, both timeouts and the trailing clock count are all parameters.

Top module: `serial_cfg_loader`

## Requirements
- R1: Out of reset the program line is high, the configuration clock is low, the bus ownership flag is 0, the ROM read strobe is high (inactive), and busy, load_done and err are all 0.
- R2: A start pulse while the loader is idle or finished drives cfg_prog_n low for exactly PROG_HOLD system clock cycles, with cfg_clk held low throughout. A start pulse while busy has no effect: no second program pulse occurs and the stream carries on unchanged.
- R3: After the program pulse, no rising cfg_clk edge occurs while cfg_init_n is low. The first rising edge follows the release of cfg_init_n within ROM_LAT + DIV_HALF + 8 system cycles, with no fixed wait.
- R4: Words are read at ROM addresses 0 to WORDS-1 in increasing order. rom_data is taken ROM_LAT cycles after the address is presented. Each word goes out bit 31 first, down to bit 0, with one bit per rising cfg_clk edge.
- R5: cfg_dout changes only while cfg_clk is low, so it is stable across every rising edge. Each high phase of cfg_clk lasts exactly DIV_HALF system cycles.
- R6: After the last bitstream bit, cfg_dout is 1 at every rising edge and the clock keeps toggling. Once cfg_done is high, TAIL_CLKS more rising edges are produced (with at most one extra for input synchronisation) before the loader finishes.
- R7: Whenever rom_own is 0, rom_addr is all zeros and rom_rd_n is 1. On finishing, rom_own drops to 0, cfg_clk rests low, busy is 0 and load_done is 1.
- R8: If cfg_init_n stays low for INIT_TIMEOUT cycles, err is set in the same cycle that a new program pulse begins, and the sequence restarts.
- R9: If cfg_done stays low for DONE_TIMEOUT cycles after the last bit, err is set and the sequence restarts with a new program pulse.
- R10: A start from the finished state performs a full new load. err is cleared when a load completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load; honoured only when idle or finished |
| cfg_init_n | input | 1 | Target's active-low init line |
| cfg_done | input | 1 | Target's done line |
| rom_data | input | WORD_W | ROM read data |
| cfg_prog_n | output | 1 | Active-low program line to the target |
| cfg_clk | output | 1 | Generated configuration clock |
| cfg_dout | output | 1 | Serial configuration data |
| rom_addr | output | ADDR_W | ROM word address, zero when released |
| rom_rd_n | output | 1 | Active-low ROM read strobe |
| rom_own | output | 1 | Output enable for the ROM address and strobe pads; 0 means high impedance |
| busy | output | 1 | A load sequence is in progress |
| load_done | output | 1 | The last load completed |
| err | output | 1 | A timeout occurred during the current sequence |

## Verification
Three ROM contents are loaded. The first is a hashed word per address, which exposes stuck, swapped or mistimed bits. The second is a single 1 that walks one position per address, which tells word order apart from bit order. The third alternates two asymmetric constants, which catches reversed bit order and a ROM word captured one cycle early. A target model holds init low for a while, releases it, raises done some cycles after the last bit, and can refuse either line; refusing each one separately shows that each timeout restarts the sequence. A start pulse in the middle of a stream and a start from the finished state separate ignored requests from honoured ones.

// File: rtl/serial_cfg_loader_pkg.sv
package serial_cfg_loader_pkg;

    typedef enum logic [2:0] {
        LD_IDLE  = 3'd0,
        LD_PROG  = 3'd1,
        LD_WINIT = 3'd2,
        LD_FETCH = 3'd3,
        LD_SHIFT = 3'd4,
        LD_TAIL  = 3'd5,
        LD_FIN   = 3'd6
    } ld_state_e;

endpackage

// File: rtl/cfg_sync.sv
// Two-stage synchroniser for asynchronous inputs from the target device.
module cfg_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d.s1 = din;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{s1: RST_VAL, s2: RST_VAL};
        else        q <= d;
    end

    assign dout = q.s2;

endmodule

// File: rtl/cfg_tick.sv
// Emits one tick every HALF cycles while enabled; restarts from zero when disabled.
module cfg_tick #(
    parameter int HALF = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);

    localparam int CW = (HALF < 2) ? 1 : $clog2(HALF);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        tick = en && (cnt_q == CW'(HALF - 1));
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import serial_cfg_loader_pkg::*;
#(
    parameter int WORDS        = 6,
    parameter int WORD_W       = 32,
    parameter int ADDR_W       = 8,
    parameter int DIV_HALF     = 12,
    parameter int ROM_LAT      = 2,
    parameter int PROG_HOLD    = 20,
    parameter int INIT_TIMEOUT = 4000,
    parameter int DONE_TIMEOUT = 4000,
    parameter int TAIL_CLKS    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_init_n,
    input  logic              cfg_done,
    input  logic [WORD_W-1:0] rom_data,
    output logic              cfg_prog_n,
    output logic              cfg_clk,
    output logic              cfg_dout,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_rd_n,
    output logic              rom_own,
    output logic              busy,
    output logic              load_done,
    output logic              err
);

    localparam int BIT_W   = $clog2(WORD_W);
    localparam int TMR_A   = (INIT_TIMEOUT > DONE_TIMEOUT) ? INIT_TIMEOUT : DONE_TIMEOUT;
    localparam int TMR_B   = (PROG_HOLD > ROM_LAT + 1) ? PROG_HOLD : ROM_LAT + 1;
    localparam int TMR_MAX = (TMR_A > TMR_B) ? TMR_A : TMR_B;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int TAIL_W  = $clog2(TAIL_CLKS + 2);

    typedef struct packed {
        ld_state_e         st;
        logic              prog_n;
        logic              cclk;
        logic              dout;
        logic              rd_n;
        logic              own;
        logic              fin;
        logic              err;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-2:0] sr;     // bits still to be sent after the current one
        logic [BIT_W-1:0]  bidx;
        logic [TMR_W-1:0]  tmr;
        logic [TAIL_W-1:0] tail;
    } ld_regs_t;

    localparam ld_regs_t RST = '{
        st: LD_IDLE, prog_n: 1'b1, cclk: 1'b0, dout: 1'b1, rd_n: 1'b1,
        own: 1'b0, fin: 1'b0, err: 1'b0, addr: '0, sr: '0, bidx: '0,
        tmr: '0, tail: '0
    };

    // Begin (or restart) a load: assert program, take the bus, clear counters.
    function automatic ld_regs_t begin_load(ld_regs_t r, logic set_err);
        ld_regs_t n;
        n        = r;
        n.st     = LD_PROG;
        n.prog_n = 1'b0;
        n.cclk   = 1'b0;
        n.dout   = 1'b1;
        n.rd_n   = 1'b0;
        n.own    = 1'b1;
        n.fin    = 1'b0;
        n.err    = set_err;
        n.addr   = '0;
        n.bidx   = '0;
        n.tmr    = '0;
        n.tail   = '0;
        return n;
    endfunction

    ld_regs_t q, d;
    logic     init_s, done_s;
    logic     tick_en, tick;

    cfg_sync #(.W(2), .RST_VAL(2'b00)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cfg_done, cfg_init_n}),
        .dout ({done_s, init_s})
    );

    assign tick_en = (q.st == LD_SHIFT) || (q.st == LD_TAIL);

    cfg_tick #(.HALF(DIV_HALF)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (tick_en),
        .tick (tick)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            LD_IDLE, LD_FIN: begin
                if (start) d = begin_load(q, 1'b0);
            end

            LD_PROG: begin
                if (q.tmr == TMR_W'(PROG_HOLD - 1)) begin
                    d.prog_n = 1'b1;
                    d.st     = LD_WINIT;
                    d.tmr    = '0;
                end else begin
                    d.tmr = q.tmr + 1'b1;
                end
            end

            LD_WINIT: begin
                if (init_s) begin
                    d.st  = LD_FETCH;
                    d.tmr = '0;
                end else if (q.tmr == TMR_W'(INIT_TIMEOUT - 1)) begin
                    d = begin_load(q, 1'b1);
                end else begin
                    d.tmr = q.tmr + 1'b1;
                end
            end

            LD_FETCH: begin
                if (q.tmr == TMR_W'(ROM_LAT)) begin
                    d.sr   = rom_data[WORD_W-2:0];
                    d.dout = rom_data[WORD_W-1];
                    d.bidx = '0;
                    d.st   = LD_SHIFT;
                    d.tmr  = '0;
                end else begin
                    d.tmr = q.tmr + 1'b1;
                end
            end

            LD_SHIFT: begin
                if (tick) begin
                    d.cclk = ~q.cclk;
                    if (q.cclk) begin
                        // falling edge: move to the next bit
                        if (q.bidx == BIT_W'(WORD_W - 1)) begin
                            if (q.addr == ADDR_W'(WORDS - 1)) begin
                                d.st   = LD_TAIL;
                                d.dout = 1'b1;
                                d.tmr  = '0;
                                d.tail = '0;
                            end else begin
                                d.addr = q.addr + 1'b1;
                                d.st   = LD_FETCH;
                                d.tmr  = '0;
                            end
                        end else begin
                            d.dout = q.sr[WORD_W-2];
                            d.sr   = {q.sr[WORD_W-3:0], 1'b0};
                            d.bidx = q.bidx + 1'b1;
                        end
                    end
                end
            end

            LD_TAIL: begin
                if (tick) begin
                    d.cclk = ~q.cclk;
                    if (!q.cclk && done_s && (q.tail < TAIL_W'(TAIL_CLKS)))
                        d.tail = q.tail + 1'b1;
                    if (q.cclk && (q.tail >= TAIL_W'(TAIL_CLKS))) begin
                        d.st   = LD_FIN;
                        d.own  = 1'b0;
                        d.rd_n = 1'b1;
                        d.fin  = 1'b1;
                        d.err  = 1'b0;
                        d.addr = '0;
                    end
                end
                if (!done_s) begin
                    if (q.tmr == TMR_W'(DONE_TIMEOUT - 1)) d = begin_load(q, 1'b1);
                    else                                   d.tmr = q.tmr + 1'b1;
                end
            end

            default: d = RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign cfg_prog_n = q.prog_n;
    assign cfg_clk    = q.cclk;
    assign cfg_dout   = q.dout;
    assign rom_addr   = q.addr;
    assign rom_rd_n   = q.rd_n;
    assign rom_own    = q.own;
    assign load_done  = q.fin;
    assign err        = q.err;
    assign busy       = (q.st != LD_IDLE) && (q.st != LD_FIN);

endmodule

// File: rtl/cfg_loader_checks.sv
module cfg_loader_checks #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_prog_n,
    input logic              cfg_clk,
    input logic              cfg_dout,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              rom_rd_n,
    input logic              rom_own,
    input logic              busy,
    input logic              load_done,
    input logic              err
);

    assert_clk_quiet_prog_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_prog_n |-> !cfg_clk);

    assert_dout_stable_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_clk && $past(cfg_clk)) |-> $stable(cfg_dout));

    assert_bus_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_own |-> (rom_addr == '0 && rom_rd_n));

    assert_finish_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> (!rom_own && !cfg_clk && !busy));

    assert_clock_needs_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_clk) |-> rom_own);

    assert_err_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (!cfg_prog_n && busy));

endmodule

bind serial_cfg_loader cfg_loader_checks #(.ADDR_W(ADDR_W)) u_checks (.*);

// File: tb/serial_cfg_loader_test.sv
module serial_cfg_loader_test;

    localparam int WORDS        = 5;
    localparam int WORD_W       = 32;
    localparam int ADDR_W       = 4;
    localparam int DIV_HALF     = 3;
    localparam int ROM_LAT      = 2;
    localparam int PROG_HOLD    = 6;
    localparam int INIT_TIMEOUT = 300;
    localparam int DONE_TIMEOUT = 300;
    localparam int TAIL_CLKS    = 4;
    localparam int TOTAL        = WORDS * WORD_W;
    localparam int INIT_DLY     = 7;
    localparam int LAT_MAX      = ROM_LAT + DIV_HALF + 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n, start, cfg_init_n, cfg_done;
    logic [WORD_W-1:0] rom_data;
    logic              cfg_prog_n, cfg_clk, cfg_dout, rom_rd_n, rom_own, busy, load_done, err;
    logic [ADDR_W-1:0] rom_addr;

    serial_cfg_loader #(
        .WORDS(WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .DIV_HALF(DIV_HALF),
        .ROM_LAT(ROM_LAT), .PROG_HOLD(PROG_HOLD), .INIT_TIMEOUT(INIT_TIMEOUT),
        .DONE_TIMEOUT(DONE_TIMEOUT), .TAIL_CLKS(TAIL_CLKS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_init_n(cfg_init_n),
        .cfg_done(cfg_done), .rom_data(rom_data), .cfg_prog_n(cfg_prog_n),
        .cfg_clk(cfg_clk), .cfg_dout(cfg_dout), .rom_addr(rom_addr),
        .rom_rd_n(rom_rd_n), .rom_own(rom_own), .busy(busy),
        .load_done(load_done), .err(err)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ROM contents
    int rom_pat = 0;
    function automatic logic [31:0] word_of(input int pat, input int a);
        case (pat)
            0:       return 32'(32'h9E3779B9 * (a + 1)) ^ 32'h0F0FF0F0;
            1:       return 32'h0000_0001 << a;
            2:       return (a % 2 == 1) ? 32'h1234_5678 : 32'hC0FF_EE01;
            default: return 32'h0;
        endcase
    endfunction

    // ROM with ROM_LAT cycles of read latency
    logic [ADDR_W-1:0] apipe [ROM_LAT];
    always @(posedge clk) begin
        apipe[0] <= rom_addr;
        for (int i = 1; i < ROM_LAT; i++) apipe[i] <= apipe[i-1];
    end
    always_comb rom_data = word_of(rom_pat, int'(apipe[ROM_LAT-1]));

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run hung actual=%0d expected=%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // Target device model, sampled away from the active edge
    bit   hold_init = 0, no_done = 0, done_out = 0, armed = 0;
    int   done_dly = 5, done_cnt = 0, init_cnt = 0, init_t = 0;
    int   rx_idx = 0, prog_pulses = 0, prog_len = 0, tail_rises = 0, hi_len = 0;
    logic prev_cclk = 0, prev_prog = 1, prev_dout = 1;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_cclk = cfg_clk;
            prev_prog = cfg_prog_n;
            prev_dout = cfg_dout;
        end else begin
            if (!rom_own)
                chk(rom_addr == '0 && rom_rd_n, "R7", "released bus idle",
                    {rom_addr, rom_rd_n}, 1);

            if (!cfg_prog_n && prev_prog) begin
                prog_pulses++;
                prog_len   = 0;
                rx_idx     = 0;
                done_out   = 0;
                done_cnt   = 0;
                tail_rises = 0;
                armed      = 1;
            end
            if (!cfg_prog_n) begin
                prog_len++;
                chk(!cfg_clk, "R2", "clock quiet in program pulse", cfg_clk, 0);
            end
            if (cfg_prog_n && !prev_prog)
                chk(prog_len == PROG_HOLD, "R2", "program pulse length", prog_len, PROG_HOLD);

            if (cfg_clk && !prev_cclk) begin
                chk(cfg_init_n, "R3", "rising edge with init low", cfg_init_n, 1);
                if (armed) begin
                    chk(cyc - init_t <= LAT_MAX, "R3", "first edge latency", cyc - init_t, LAT_MAX);
                    armed = 0;
                end
                if (rx_idx < TOTAL) begin
                    logic [31:0] w;
                    logic        eb;
                    w  = word_of(rom_pat, rx_idx / WORD_W);
                    eb = w[WORD_W - 1 - (rx_idx % WORD_W)];
                    if (cfg_dout !== eb)
                        $display("  R4 mismatch at bit %0d", rx_idx);
                    chk(cfg_dout === eb, "R4", "stream bit", cfg_dout, eb);
                    rx_idx++;
                end else begin
                    chk(cfg_dout == 1'b1, "R6", "startup data held at 1", cfg_dout, 1);
                    if (done_out) tail_rises++;
                end
                hi_len = 1;
            end else if (cfg_clk) begin
                hi_len++;
            end
            if (!cfg_clk && prev_cclk && cfg_prog_n)
                chk(hi_len == DIV_HALF, "R5", "clock high length", hi_len, DIV_HALF);
            if (cfg_clk && prev_cclk)
                chk(cfg_dout == prev_dout, "R5", "data moved while clock high", cfg_dout, prev_dout);

            if (!cfg_prog_n) begin
                cfg_init_n = 1'b0;
                init_cnt   = 0;
            end else if (hold_init) begin
                cfg_init_n = 1'b0;
            end else if (!cfg_init_n) begin
                if (init_cnt >= INIT_DLY) begin
                    cfg_init_n = 1'b1;
                    init_t     = cyc;
                end else begin
                    init_cnt++;
                end
            end

            if (rx_idx == TOTAL && !no_done && !done_out) begin
                if (done_cnt >= done_dly) done_out = 1;
                else                      done_cnt++;
            end
            cfg_done = done_out;

            prev_cclk = cfg_clk;
            prev_prog = cfg_prog_n;
            prev_dout = cfg_dout;
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_load_done();
        while (!load_done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_checks(input string req);
        chk(rx_idx == TOTAL, req, "bits received", rx_idx, TOTAL);
        chk(tail_rises >= TAIL_CLKS && tail_rises <= TAIL_CLKS + 1, "R6",
            "edges after done", tail_rises, TAIL_CLKS);
        chk(!rom_own && rom_rd_n && rom_addr == '0, "R7", "bus handed over",
            {rom_own, rom_rd_n, rom_addr}, 1 << ADDR_W);
        chk(!busy && load_done && !cfg_clk, "R7", "finished status",
            {busy, load_done, cfg_clk}, 3'b010);
        chk(!err, "R10", "err clear after completion", err, 0);
    endtask

    initial begin
        int base;
        rst_n      = 1'b0;
        start      = 1'b0;
        cfg_init_n = 1'b0;
        cfg_done   = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk(cfg_prog_n && !cfg_clk && rom_rd_n && !rom_own, "R1", "reset pins",
            {cfg_prog_n, cfg_clk, rom_rd_n, rom_own}, 4'b1010);
        chk(!busy && !load_done && !err, "R1", "reset status", {busy, load_done, err}, 0);

        // Load with hashed words; mid-stream start must be ignored (R2)
        rom_pat = 0;
        pulse_start();
        chk(busy && !cfg_prog_n, "R2", "program pulse begins", {busy, cfg_prog_n}, 2'b10);
        while (rx_idx < 40) @(negedge clk);
        pulse_start();
        wait_load_done();
        chk(prog_pulses == 1, "R2", "start ignored while busy", prog_pulses, 1);
        finish_checks("R4");

        // Walking-one words, started again from the finished state (R10)
        rom_pat = 1;
        base    = prog_pulses;
        pulse_start();
        wait_load_done();
        chk(prog_pulses == base + 1, "R10", "reload from finished", prog_pulses, base + 1);
        finish_checks("R10");

        // Init held low: timeout, error, restart (R8)
        rom_pat   = 2;
        hold_init = 1;
        base      = prog_pulses;
        pulse_start();
        while (!err) @(negedge clk);
        @(negedge clk);
        chk(!cfg_prog_n && busy, "R8", "restart pulse after init timeout",
            {cfg_prog_n, busy}, 2'b01);
        chk(prog_pulses == base + 2, "R8", "second program pulse", prog_pulses, base + 2);
        chk(rx_idx == 0, "R3", "no bits while init low", rx_idx, 0);
        hold_init = 0;
        wait_load_done();
        finish_checks("R8");

        // Done never rises: timeout, error, restart (R9)
        rom_pat  = 0;
        no_done  = 1;
        base     = prog_pulses;
        pulse_start();
        while (rx_idx < TOTAL) @(negedge clk);
        while (!err) @(negedge clk);
        @(negedge clk);
        chk(!cfg_prog_n && busy, "R9", "restart pulse after done timeout",
            {cfg_prog_n, busy}, 2'b01);
        chk(prog_pulses == base + 2, "R9", "second program pulse", prog_pulses, base + 2);
        no_done  = 0;
        done_dly = 12;
        wait_load_done();
        finish_checks("R9");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule